// File: doc/BRIEF.md
# Parallel ROM/Flash Wait-State Controller

This block sits between an internal request bus and an asynchronous parallel PROM or flash part. Each accepted request becomes one device access whose chip-select and output-enable (for reads) or write-enable (for writes) stay low for a programmed number of system clocks. On the last of those clocks the block raises a one-cycle response strobe, and a read returns the device data sampled in that cycle.

Two 32-bit configuration words control the block. A plain register port writes and reads them. The mode word holds a two-bit size model, which sets how many device address bits are driven, and a write-permit bit. The timing word holds a three-bit access-length code. Once the larger size model is selected, it cannot be changed back. While the permit bit is clear, write requests are answered at once and never reach the device.

The request side is a valid/ready handshake. `req_ready` is high only while no access is in flight. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The address, data and direction are captured on that edge. The response side has no back-pressure. `rsp_valid` is a single-cycle strobe that the requester must take in that cycle. No new request is accepted until the cycle after the strobe.

Top module: `romwait_ctrl`

## Requirements
- R1: After reset both configuration words read 0, `dev_cs_n`, `dev_oe_n` and `dev_we_n` are high, and `req_ready` is high.
- R2: The size field is mode-word bits 1:0, with 00 selecting a 4 MB space and 01 an 8 MB space. A write carrying code 10 or 11 leaves the field unchanged.
- R3: After the size field has taken the value 01, later writes never change it, while other mode-word fields still update.
- R4: The write-permit bit is mode-word bit 8. With it at 0, a write request gets `rsp_valid` in the first cycle after acceptance, and neither `dev_cs_n` nor `dev_we_n` goes low.
- R5: With bit 8 at 1, a write request drives `dev_we_n` low for the whole access and presents the request data on `dev_dout` with `dev_dout_en` high.
- R6: The access length in clocks is set by timing-word bits 2:0: code 0 gives 18, and code c from 1 to 7 gives 2c+2. `dev_cs_n` stays low for exactly that many consecutive cycles, starting the cycle after acceptance.
- R7: `rsp_valid` is high for exactly one cycle, the final low cycle of `dev_cs_n`. For a read, `rsp_rdata` equals `dev_din` in that cycle.
- R8: All mode-word bits other than 1:0 and 8, and all timing-word bits above bit 2, read back as 0 whatever was written.
- R9: `dev_addr` carries request address bits 21:0 with bit 22 forced to 0 in the 4 MB model, and bits 22:0 in the 8 MB model. It is held stable for the whole access.
- R10: A timing-word write made while an access is in flight does not change that access's length. It applies from the next access on.
- R11: `req_ready` is low from the cycle after acceptance until the response cycle. `dev_cs_n` returns high in the cycle after the response.
- R12: `dev_oe_n` is low only during read accesses and `dev_we_n` only during write accesses. The two are never low together, and neither is low while `dev_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_sel | input | 1 | Word select: 0 mode word, 1 timing word (write and readback) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle access completion strobe |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` on reads |
| dev_cs_n | output | 1 | Device chip-select, active low |
| dev_oe_n | output | 1 | Device output-enable, active low |
| dev_we_n | output | 1 | Device write-enable, active low |
| dev_addr | output | 23 | Device address |
| dev_dout | output | 16 | Data driven toward the device |
| dev_dout_en | output | 1 | Output enable for the data pins toward the device |
| dev_din | input | 16 | Data returned by the device |

## Verification
Reads are swept through all eight timing codes. For each code the bench measures the chip-select low time, the response position and the returned data. This separates the code-0 special case from the linear 2c+2 codes and catches off-by-one counting. The same sweep is then run with writes under both states of the permit bit, which separates the one-cycle masked path from the full strobe path. Address patterns with bit 22 and higher bits set are issued in each size model to expose truncation faults. The size field is hit with reserved codes before and after the lock, and a timing-word write is issued mid-access to check that the access in flight keeps its length.

// File: rtl/romwait_pkg.sv
package romwait_pkg;

  localparam int CFG_W   = 32;
  localparam int CNT_W   = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_DROP = 2'd2
  } seq_state_t;

  // Access length in clocks for a timing code; code 0 is the longest.
  function automatic logic [CNT_W-1:0] access_len(input logic [2:0] code);
    logic [CNT_W-1:0] len;
    if (code == 3'd0) len = 5'd18;
    else              len = {1'b0, code, 1'b0} + 5'd2;
    return len;
  endfunction

endpackage

// File: rtl/romwait_regs.sv
module romwait_regs
  import romwait_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [1:0]       size_o,
  output logic             wpermit_o,
  output logic [2:0]       tcode_o
);

  logic [1:0] size_q;
  logic       lock_q;
  logic       wpermit_q;
  logic [2:0] tcode_q;
  logic       mode_wr;
  logic       size_take;
  logic       unused_bits;

  assign mode_wr     = wr_en && !sel;
  assign size_take   = mode_wr && !lock_q && !wdata[1];
  assign unused_bits = ^{wdata[31:9], wdata[7:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= 2'b00;
      lock_q    <= 1'b0;
      wpermit_q <= 1'b0;
      tcode_q   <= 3'd0;
    end else begin
      if (mode_wr) wpermit_q <= wdata[8];
      if (size_take) begin
        size_q <= wdata[1:0];
        if (wdata[0]) lock_q <= 1'b1;
      end
      if (wr_en && sel) tcode_q <= wdata[2:0];
    end
  end

  always_comb begin
    if (sel) rdata = {29'd0, tcode_q};
    else     rdata = {23'd0, wpermit_q, 6'd0, size_q};
  end

  assign size_o    = size_q;
  assign wpermit_o = wpermit_q;
  assign tcode_o   = tcode_q;

  assert_size_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    size_q[1] == 1'b0);

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && size_q == 2'b01));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[31:9] == 23'd0) && (rdata[7:3] == 5'd0));

endmodule

// File: rtl/romwait_addr.sv
module romwait_addr #(
  parameter int BUS_AW = 32,
  parameter int DEV_AW = 23
) (
  input  logic [BUS_AW-1:0] addr_in,
  input  logic              big_model,
  output logic [DEV_AW-1:0] addr_out
);

  logic unused_hi;
  assign unused_hi = ^addr_in[BUS_AW-1:DEV_AW];

  for (genvar i = 0; i < DEV_AW; i++) begin : g_bit
    if (i == DEV_AW - 1) begin : g_top
      assign addr_out[i] = addr_in[i] & big_model;
    end else begin : g_pass
      assign addr_out[i] = addr_in[i];
    end
  end

endmodule

// File: rtl/romwait_seq.sv
module romwait_seq
  import romwait_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEV_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DEV_AW-1:0] req_daddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wpermit,
  input  logic [2:0]        tcode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dev_cs_n,
  output logic              dev_oe_n,
  output logic              dev_we_n,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_dout_en,
  input  logic [DATA_W-1:0] dev_din
);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  left_q;
  logic              wr_q;
  logic [DEV_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;
  logic              busy;
  logic              last;

  assign take = req_valid && (state_q == SEQ_IDLE);
  assign busy = (state_q == SEQ_BUSY);
  assign last = busy && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (take) begin
            if (req_write && !wpermit) begin
              state_q <= SEQ_DROP;
            end else begin
              state_q <= SEQ_BUSY;
              left_q  <= access_len(tcode) - 5'd1;
              wr_q    <= req_write;
              addr_q  <= req_daddr;
              wdata_q <= req_wdata;
            end
          end
        end
        SEQ_BUSY: begin
          if (left_q == '0) begin
            state_q <= SEQ_IDLE;
            if (!wr_q) rdata_q <= dev_din;
          end else begin
            left_q <= left_q - 5'd1;
          end
        end
        SEQ_DROP: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == SEQ_IDLE);
  assign rsp_valid   = last || (state_q == SEQ_DROP);
  assign rsp_rdata   = (last && !wr_q) ? dev_din : rdata_q;
  assign dev_cs_n    = !busy;
  assign dev_oe_n    = !(busy && !wr_q);
  assign dev_we_n    = !(busy && wr_q);
  assign dev_addr    = addr_q;
  assign dev_dout    = wdata_q;
  assign dev_dout_en = busy && wr_q;

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q < 5'd18));

  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_DROP) |-> (dev_cs_n && dev_we_n && rsp_valid));

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dev_cs_n);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_oe_n && !dev_we_n));

  assert_strobe_in_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_oe_n || !dev_we_n) |-> !dev_cs_n);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_cs_n && left_q != '0) |=> $stable(dev_addr));

  assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q != '0) |=> (left_q == $past(left_q) - 5'd1));

endmodule

// File: rtl/romwait_ctrl.sv
module romwait_ctrl
  import romwait_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter int DEV_AW = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dev_cs_n,
  output logic              dev_oe_n,
  output logic              dev_we_n,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_dout_en,
  input  logic [DATA_W-1:0] dev_din
);

  logic [1:0]        size_model;
  logic              wpermit;
  logic [2:0]        tcode;
  logic [DEV_AW-1:0] daddr;

  romwait_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .size_o    (size_model),
    .wpermit_o (wpermit),
    .tcode_o   (tcode)
  );

  romwait_addr #(.BUS_AW(BUS_AW), .DEV_AW(DEV_AW)) u_addr (
    .addr_in   (req_addr),
    .big_model (size_model[0]),
    .addr_out  (daddr)
  );

  romwait_seq #(.DATA_W(DATA_W), .DEV_AW(DEV_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_daddr   (daddr),
    .req_wdata   (req_wdata),
    .wpermit     (wpermit),
    .tcode       (tcode),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .dev_cs_n    (dev_cs_n),
    .dev_oe_n    (dev_oe_n),
    .dev_we_n    (dev_we_n),
    .dev_addr    (dev_addr),
    .dev_dout    (dev_dout),
    .dev_dout_en (dev_dout_en),
    .dev_din     (dev_din)
  );

  assert_small_trunc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_cs_n && size_model == 2'b00) |-> (dev_addr[DEV_AW-1] == 1'b0));

  assert_masked_nowe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_we_n) |-> dev_dout_en);

endmodule

// File: tb/romwait_ctrl_tb.sv
module romwait_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        dev_cs_n, dev_oe_n, dev_we_n, dev_dout_en;
  logic [22:0] dev_addr;
  logic [15:0] dev_dout;
  logic [15:0] dev_din;

  int checks = 0;
  int fails  = 0;
  bit big_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dev_din = dev_addr[15:0] ^ 16'h5A3C;

  romwait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_cs_n(dev_cs_n), .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n),
    .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_dout_en(dev_dout_en), .dev_din(dev_din)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  function automatic int len_of(input int code);
    return (code == 0) ? 18 : 2 * code + 2;
  endfunction

  // Runs one access and reports what was seen at the ports.
  task automatic run_acc(input bit w, input logic [31:0] a, input logic [15:0] d,
                         output int lat, output int cs_cnt, output int oe_cnt, output int we_cnt,
                         output logic [22:0] seen_addr, output logic [15:0] seen_dout,
                         output logic [15:0] rd, output bit busy_rdy, output bit addr_moved,
                         output bit cs_after);
    bit seen = 0;
    lat = 0; cs_cnt = 0; oe_cnt = 0; we_cnt = 0; busy_rdy = 0; addr_moved = 0;
    seen_addr = '0; seen_dout = '0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (i > 0) @(negedge clk);
      lat++;
      if (!dev_cs_n) begin
        if (cs_cnt == 0) begin seen_addr = dev_addr; seen_dout = dev_dout; end
        else if (dev_addr != seen_addr) addr_moved = 1;
        cs_cnt++;
      end
      if (!dev_oe_n) oe_cnt++;
      if (!dev_we_n && dev_dout_en) we_cnt++;
      if (req_ready && !rsp_valid) busy_rdy = 1;
      if (rsp_valid) begin seen = 1; rd = rsp_rdata; end
    end
    @(negedge clk);
    cs_after = dev_cs_n;
  endtask

  function automatic logic [22:0] exp_addr(input logic [31:0] a);
    return big_model ? a[22:0] : {1'b0, a[21:0]};
  endfunction

  // Read access with full checking of length, strobes, address and data.
  task automatic read_chk(input logic [31:0] a, input int n, input string tag);
    int lat, cs, oe, we; logic [22:0] sa; logic [15:0] sd, rd; bit br, mv, ca;
    logic [22:0] ea;
    ea = exp_addr(a);
    run_acc(1'b0, a, 16'h0, lat, cs, oe, we, sa, sd, rd, br, mv, ca);
    chk(cs == n, {tag, " R6 cs length"}, cs, n);
    chk(lat == n, {tag, " R7 rsp position"}, lat, n);
    chk(oe == n && we == 0, {tag, " R12 read strobes"}, {oe, we}, n);
    chk(rd == (ea[15:0] ^ 16'h5A3C), {tag, " R7 read data"}, rd, ea[15:0] ^ 16'h5A3C);
    chk(sa == ea && !mv, {tag, " R9 device address"}, sa, ea);
    chk(!br && ca, {tag, " R11 ready/cs release"}, {br, ca}, 1);
  endtask

  logic [31:0] rv;
  int lat, cs, oe, we; logic [22:0] sa; logic [15:0] sd, rd; bit br, mv, ca;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_read(1'b0, rv); chk(rv == 0, "R1 mode word", rv, 0);
    cfg_read(1'b1, rv); chk(rv == 0, "R1 timing word", rv, 0);
    chk(dev_cs_n && dev_oe_n && dev_we_n && req_ready, "R1 idle pins",
        {dev_cs_n, dev_oe_n, dev_we_n, req_ready}, 4'hF);

    // R8 reserved timing bits
    cfg_write(1'b1, 32'hFFFF_FFF8); cfg_read(1'b1, rv); chk(rv == 0, "R8 timing rsvd", rv, 0);
    cfg_write(1'b1, 32'hFFFF_FFFD); cfg_read(1'b1, rv); chk(rv == 5, "R8 timing rsvd", rv, 5);

    // R6 sweep of reads over all codes, 4 MB model, high address bits set
    for (int c = 0; c < 8; c++) begin
      cfg_write(1'b1, c);
      read_chk(32'hFFC0_0000 | (c * 32'h1357), len_of(c), $sformatf("code%0d", c));
    end

    // R4 masked writes: one-cycle response, no strobes
    for (int c = 0; c < 8; c += 3) begin
      cfg_write(1'b1, c);
      run_acc(1'b1, 32'h0000_0100 + c, 16'hBEEF, lat, cs, oe, we, sa, sd, rd, br, mv, ca);
      chk(lat == 1 && cs == 0 && we == 0, "R4 masked write", {lat, cs, we}, 1);
    end

    // R5 permitted writes over all codes
    cfg_write(1'b0, 32'h0000_0100);
    cfg_read(1'b0, rv); chk(rv == 32'h100, "R4 permit readback", rv, 32'h100);
    for (int c = 0; c < 8; c++) begin
      cfg_write(1'b1, c);
      run_acc(1'b1, 32'h0040_0000 | (c * 32'h2222), 16'h1000 + c[15:0],
              lat, cs, oe, we, sa, sd, rd, br, mv, ca);
      chk(we == len_of(c) && cs == len_of(c) && oe == 0, "R5 write strobe length", we, len_of(c));
      chk(sd == 16'h1000 + c[15:0], "R5 write data", sd, 16'h1000 + c);
      chk(sa == exp_addr(32'h0040_0000 | (c * 32'h2222)), "R9 write address", sa,
          exp_addr(32'h0040_0000 | (c * 32'h2222)));
    end

    // R2 reserved size codes and R8 reserved mode bits
    cfg_write(1'b0, 32'h0000_0102); cfg_read(1'b0, rv); chk(rv == 32'h100, "R2 code 10 ignored", rv, 32'h100);
    cfg_write(1'b0, 32'hFFFF_FFFF); cfg_read(1'b0, rv); chk(rv == 32'h100, "R2 R8 code 11 / rsvd", rv, 32'h100);

    // R10 timing change mid-access
    cfg_write(1'b1, 0);
    fork
      run_acc(1'b0, 32'h0000_0444, 16'h0, lat, cs, oe, we, sa, sd, rd, br, mv, ca);
      begin repeat (4) @(negedge clk); cfg_write(1'b1, 1); end
    join
    chk(cs == 18, "R10 in-flight length", cs, 18);
    read_chk(32'h0000_0445, 4, "R10 next access");

    // R2 R3 switch to 8 MB then lock
    cfg_write(1'b0, 32'h0000_0001); big_model = 1'b1;
    cfg_read(1'b0, rv); chk(rv == 1, "R2 size 01", rv, 1);
    cfg_write(1'b1, 2);
    read_chk(32'h00FF_FFFF, 6, "R9 8MB");
    cfg_write(1'b0, 32'h0000_0100); cfg_read(1'b0, rv); chk(rv == 32'h101, "R3 lock keeps size", rv, 32'h101);
    cfg_write(1'b0, 32'h0000_0002); cfg_read(1'b0, rv); chk(rv == 32'h001, "R3 lock, permit updates", rv, 32'h001);
    read_chk(32'h0040_1234, 6, "R3 still 8MB");

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule